// File: doc/BRIEF.md
# Timeslot-Zero Alignment Word Sequencer

This block supplies the 8-bit word that goes out in synchronization channel 0 of each frame in a 16-frame multiframe. A frame counter tracks the position inside the multiframe. Each frame start is marked by a strobe. On that strobe the counter moves to the next frame, and the block registers the word that belongs to the new frame.

Odd frames carry a fixed alignment pattern. Even frames carry a service word, and its status and service fields come from live inputs. In both kinds of frame the first bit is a per-frame check bit. That bit is computed upstream by the CRC procedure and arrives on an input. The block does not compute the CRC, serialize the word or check alignment on the receive side. A one-cycle flag marks the start of each new multiframe.

Top module: `ts0_word_seq`

## Requirements
- R1: `frame_no` only takes values from 1 to 16. Reset sets `frame_no` to 1, `word_o` to 8'h1B (frame-1 pattern with bit 7 at 0) and `mf_start` to 0.
- R2: Each cycle with `frame_stb` high, `frame_no` goes up by one in the next cycle when it was below 16.
- R3: A strobe taken while `frame_no` is 16 sets `frame_no` to 1 and raises `mf_start` for exactly one cycle. In all other cycles `mf_start` is 0.
- R4: When the strobe enters an odd frame, `word_o[6:0]` becomes 7'b0011011 (bit 6 down to bit 0).
- R5: When the strobe enters an even frame, `word_o` = {X, 1, `err_d`, `err_n`, `svc_y[3:0]`}. Bit 6 is 1, bit 5 is D, bit 4 is N and bits 3..0 are Y.
- R6: In a cycle without a strobe, `word_o` and `frame_no` keep their values, whatever the other inputs do.
- R7: On every strobe, `word_o[7]` takes the value of `crc_bit` sampled in that strobe cycle. This holds for both odd and even frames.
- R8: In odd frames, `err_d`, `err_n` and `svc_y` have no effect on `word_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One-cycle frame start strobe |
| crc_bit | input | 1 | Check bit for the word of the frame being entered |
| err_d | input | 1 | D status bit (error indication) |
| err_n | input | 1 | N status bit (error indication) |
| svc_y | input | 4 | Service bits Y3..Y0 |
| word_o | output | 8 | Channel-0 word, MSB first (bit 7 sent first) |
| frame_no | output | 5 | Current frame number, 1..16 |
| mf_start | output | 1 | One-cycle pulse when frame 1 begins |

## Verification
The assertions check the following on every cycle:
- the frame range;
- the step and wrap of the counter;
- the fixed odd-frame tail;
- the forced bit 6 in even frames;
- holding of the outputs between strobes;
- the transfer of the check bit into bit 7.

Only the bench scenarios can show these:
- that the D, N and Y fields land in the right bit positions with the right values;
- that those fields are ignored in odd frames;
- the exact words produced over a full multiframe and a second wrap;
- the reset behaviour in the middle of a multiframe.

// File: rtl/ts0_word_seq.sv
module ts0_word_seq #(
  parameter int          MF_LEN     = 16,
  parameter logic [6:0]  ALIGN_TAIL = 7'b0011011,
  localparam int         FW         = $clog2(MF_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic          crc_bit,
  input  logic          err_d,
  input  logic          err_n,
  input  logic [3:0]    svc_y,
  output logic [7:0]    word_o,
  output logic [FW-1:0] frame_no,
  output logic          mf_start
);

  logic          at_last;
  logic [FW-1:0] frame_nxt;
  logic [7:0]    word_nxt;

  assign at_last   = (frame_no == FW'(MF_LEN));
  assign frame_nxt = at_last ? FW'(1) : frame_no + FW'(1);
  assign word_nxt  = frame_nxt[0] ? {crc_bit, ALIGN_TAIL}
                                  : {crc_bit, 1'b1, err_d, err_n, svc_y};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_no <= FW'(1);
      word_o   <= {1'b0, ALIGN_TAIL};
      mf_start <= 1'b0;
    end else begin
      mf_start <= frame_stb && at_last;
      if (frame_stb) begin
        frame_no <= frame_nxt;
        word_o   <= word_nxt;
      end
    end
  end

endmodule

// File: rtl/ts0_word_seq_chk.sv
module ts0_word_seq_chk #(
  parameter int         MF_LEN     = 16,
  parameter logic [6:0] ALIGN_TAIL = 7'b0011011,
  localparam int        FW         = $clog2(MF_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_stb,
  input logic          crc_bit,
  input logic [7:0]    word_o,
  input logic [FW-1:0] frame_no,
  input logic          mf_start
);

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_no >= FW'(1)) && (frame_no <= FW'(MF_LEN))); // R1

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && frame_no != FW'(MF_LEN)) |=> (frame_no == $past(frame_no) + FW'(1))); // R2

  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && frame_no == FW'(MF_LEN)) |=> (frame_no == FW'(1) && mf_start)); // R3

  AST_MF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |=> !mf_start); // R3

  AST_MF_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> (frame_no == FW'(1))); // R3

  AST_ODD_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_no[0] |-> (word_o[6:0] == ALIGN_TAIL)); // R4

  AST_EVEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_no[0] |-> word_o[6]); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(word_o) && $stable(frame_no))); // R6

  AST_XBIT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> (word_o[7] == $past(crc_bit))); // R7

endmodule

bind ts0_word_seq ts0_word_seq_chk #(.MF_LEN(MF_LEN), .ALIGN_TAIL(ALIGN_TAIL)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .crc_bit(crc_bit),
  .word_o(word_o), .frame_no(frame_no), .mf_start(mf_start)
);

// File: tb/ts0_word_seq_tb.sv
module ts0_word_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic       crc_bit = 1'b0;
  logic       err_d = 1'b0;
  logic       err_n = 1'b0;
  logic [3:0] svc_y = 4'h0;
  logic [7:0] word_o;
  logic [4:0] frame_no;
  logic       mf_start;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ts0_word_seq u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .crc_bit(crc_bit),
    .err_d(err_d), .err_n(err_n), .svc_y(svc_y),
    .word_o(word_o), .frame_no(frame_no), .mf_start(mf_start)
  );

  // stimulus {x, d, n, y[3:0]} for strobes entering frames 2..16 then 1
  localparam logic [6:0] STIM [16] = '{
    7'b1_0_0_1010, 7'b0_1_1_1111, 7'b0_1_0_0101, 7'b1_0_1_0000,
    7'b1_1_1_1111, 7'b1_1_1_1111, 7'b0_0_0_0000, 7'b0_0_0_0000,
    7'b0_0_1_0011, 7'b1_0_0_0000, 7'b1_1_0_1100, 7'b0_0_1_1001,
    7'b1_0_0_0001, 7'b0_1_1_0110, 7'b0_1_1_1000, 7'b1_1_0_0110
  };
  localparam logic [7:0] EXPW [16] = '{
    8'hCA, 8'h1B, 8'h65, 8'h9B, 8'hFF, 8'h9B, 8'h40, 8'h1B,
    8'h53, 8'h9B, 8'hEC, 8'h1B, 8'hC1, 8'h1B, 8'h78, 8'h9B
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [6:0] s);
    @(negedge clk);
    {crc_bit, err_d, err_n, svc_y} = s;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset frame", frame_no, 1);
    check("R1 reset word", word_o, 8'h1B);
    check("R1 reset mf_start", mf_start, 0);

    for (int i = 0; i < 16; i++) begin
      strobe(STIM[i]);
      check("R4 R5 R7 word", word_o, EXPW[i]);
      check("R2 frame", frame_no, (i == 15) ? 1 : i + 2);
      check("R3 mf_start", mf_start, (i == 15) ? 1 : 0);
      @(negedge clk);
      check("R3 mf_start one cycle", mf_start, 0);
    end

    // R6: inputs move without a strobe
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      {crc_bit, err_d, err_n, svc_y} = 7'(k * 37 + 5);
    end
    @(negedge clk);
    check("R6 hold word", word_o, 8'h9B);
    check("R6 hold frame", frame_no, 1);

    // R8: odd frame ignores D/N/Y
    strobe(7'b0_0_0_0000);
    check("R5 frame 2 zeros", word_o, 8'h40);
    strobe(7'b0_1_1_1111);
    check("R8 odd ignores fields", word_o, 8'h1B);
    strobe(7'b1_1_1_1111);
    check("R5 frame 4 ones", word_o, 8'hFF);
    strobe(7'b1_0_0_0000);
    check("R7 R8 odd X", word_o, 8'h9B);

    // run to frame 16 then wrap again
    for (int f = 6; f <= 16; f++) strobe(7'b0_1_0_1001);
    check("R2 reach 16", frame_no, 16);
    check("R5 frame 16 word", word_o, 8'h69);
    strobe(7'b0_1_0_1001);
    check("R3 second wrap frame", frame_no, 1);
    check("R3 second wrap flag", mf_start, 1);
    @(negedge clk);
    check("R3 second wrap pulse ends", mf_start, 0);

    // reset mid-multiframe
    strobe(7'b1_0_0_0000);
    strobe(7'b1_0_0_0000);
    check("R2 frame 3", frame_no, 3);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 mid reset frame", frame_no, 1);
    check("R1 mid reset word", word_o, 8'h1B);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule